// File: doc/BRIEF.md
# Multi-Lane Serial Master with Held Frame Select

This block is a serial master that takes queued command entries and shifts each one out as a byte over one, two or four data lanes. Each entry carries the data byte, a lane mode, a direction bit and an end-of-message flag. The engine generates a serial clock that idles low. Data changes while the clock is low and is sampled on the rising edge. The engine also drives an active-low frame-select line. Bytes taken in from the lanes are placed in a receive queue, which the host reads.

The frame-select line works in one of two ways, chosen by a control input. In the first, frame-select marks only the first serial clock of every byte. In the second, frame-select stays low from the first byte of a frame until the byte flagged end-of-message has finished, and it also stays low across gaps when the queue is empty. The lane width can change from one entry to the next. A change between dual and quad inside one held frame is reported as an error.

Top module: `mls_master`

## Requirements
- R1: An entry's byte is sent MSB first. Mode 00 (single) drives lane 0 for 8 serial clocks. Mode 01 (dual) drives lanes 1:0 for 4 clocks, with the earlier bit on lane 1. Mode 10 (quad) drives lanes 3:0 for 2 clocks, with the earliest bit on lane 3. Mode 11 is treated as single.
- R2: Each serial clock period lasts two ticks: one tick low, then one tick high. The lane outputs never change while the serial clock is high.
- R3: When hold_frame is 0 at the start of a frame, each byte is its own frame. fs_n is low during that byte's first serial clock only.
- R4: When hold_frame is 1 at the start of a frame (it is latched there), fs_n goes low when the first byte starts. It rises only after the last falling clock edge of a byte whose end-of-message flag is set, and it falls exactly once per frame.
- R5: If the transmit queue is empty during a held frame, the serial clock stays low, fs_n stays low and busy stays high until a new entry arrives.
- R6: A single-lane byte always drives lane 0 and captures lane 1. A dual or quad entry with the direction bit set to 1 releases every lane (lane_oe = 0) and captures the lanes. Every captured byte is pushed into the receive queue. A dual or quad entry with the direction bit set to 0 pushes nothing.
- R7: Inside a held frame, a direct change between dual and quad raises mode_err for exactly one cycle, and the byte is still sent in its own mode. A change to or from single raises no error.
- R8: busy is high whenever fs_n is low or a byte is shifting, and is low otherwise.
- R9: After reset: fs_n = 1, sclk = 0, lane_oe = 0, busy = 0, mode_err = 0, rx_empty = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable, one serial clock phase per tick |
| hold_frame | input | 1 | 1 = hold frame-select for a whole frame |
| tx_wr | input | 1 | Push an entry into the transmit queue |
| tx_data | input | 8 | Entry data byte |
| tx_eom | input | 1 | Entry end-of-message flag |
| tx_mode | input | 2 | Entry lane mode (00 single, 01 dual, 10 quad) |
| tx_rx | input | 1 | Dual/quad direction, 1 = receive |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the receive queue head |
| rx_data | output | 8 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, idle low |
| fs_n | output | 1 | Active-low frame select |
| lane_out | output | 4 | Lane output values |
| lane_oe | output | 4 | Lane output enables |
| lane_in | input | 4 | Lane input values |
| busy | output | 1 | Frame open or byte in progress |
| mode_err | output | 1 | One-cycle dual/quad switch error pulse |

## Verification
A host write into the transmit queue can land in the same cycle that the engine pops the queue head. To provoke this, a held frame is queued with back-to-back writes while the tick runs every cycle, so the second write meets the first pop. The test passes if every byte comes out in write order with a single frame-select fall. A second overlap is the error pulse meeting a lane-width change. This is judged by checking that the byte which caused the error is still rebuilt correctly from the lanes.

// File: rtl/mls_pkg.sv
package mls_pkg;

  typedef enum logic [1:0] {
    LM_SINGLE = 2'b00,
    LM_DUAL   = 2'b01,
    LM_QUAD   = 2'b10,
    LM_RSVD   = 2'b11
  } lane_mode_e;

  typedef struct packed {
    logic [7:0] data;
    logic       eom;
    logic       rx_dir;
    lane_mode_e mode;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  function automatic logic is_multi(lane_mode_e m);
    return (m == LM_DUAL) || (m == LM_QUAD);
  endfunction

  function automatic logic [2:0] last_clk(lane_mode_e m);
    case (m)
      LM_QUAD: return 3'd1;
      LM_DUAL: return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(lane_mode_e m);
    case (m)
      LM_QUAD: return 4'hF;
      LM_DUAL: return 4'h3;
      default: return 4'h1;
    endcase
  endfunction

  function automatic logic [3:0] out_bits(logic [7:0] s, lane_mode_e m);
    case (m)
      LM_QUAD: return s[7:4];
      LM_DUAL: return {2'b00, s[7:6]};
      default: return {3'b000, s[7]};
    endcase
  endfunction

  function automatic logic [7:0] shift_out(logic [7:0] s, lane_mode_e m);
    case (m)
      LM_QUAD: return {s[3:0], 4'b0000};
      LM_DUAL: return {s[5:0], 2'b00};
      default: return {s[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] shift_in(logic [7:0] r, logic [3:0] ln, lane_mode_e m);
    case (m)
      LM_QUAD: return {r[3:0], ln};
      LM_DUAL: return {r[5:0], ln[1:0]};
      default: return {r[6:0], ln[1]};
    endcase
  endfunction

  function automatic logic bad_switch(lane_mode_e a, lane_mode_e b);
    return ((a == LM_DUAL) && (b == LM_QUAD)) || ((a == LM_QUAD) && (b == LM_DUAL));
  endfunction

endpackage

// File: rtl/mls_fifo.sv
module mls_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;

  wire do_wr = wr && !full;
  wire do_rd = rd && !empty;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mls_engine.sv
module mls_engine
  import mls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold_frame,
  input  entry_t     head,
  input  logic       head_valid,
  output logic       pop,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       fs_n,
  output logic [3:0] lane_out,
  output logic [3:0] lane_oe,
  input  logic [3:0] lane_in,
  output logic       busy,
  output logic       mode_err
);
  logic       active, phase, frame_open, hold_l;
  logic [2:0] cnt;
  entry_t     cur;
  logic [7:0] sh, rsh;
  lane_mode_e prev_mode;

  // named internal events
  wire start     = tick && !active && head_valid;
  wire rise      = tick && active && !phase;
  wire fall      = tick && active && phase;
  wire byte_done = fall && (cnt == last_clk(cur.mode));
  wire capture   = !is_multi(cur.mode) || cur.rx_dir;
  wire releasing = byte_done && (!hold_l || cur.eom);
  wire conflict  = start && frame_open && bad_switch(prev_mode, head.mode);
  wire drive     = active && !(is_multi(cur.mode) && cur.rx_dir);

  assign pop     = start;
  assign rx_push = byte_done && capture;
  assign rx_byte = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      phase      <= 1'b0;
      frame_open <= 1'b0;
      hold_l     <= 1'b0;
      cnt        <= '0;
      cur        <= '0;
      sh         <= '0;
      rsh        <= '0;
      prev_mode  <= LM_SINGLE;
      mode_err   <= 1'b0;
    end else begin
      mode_err <= 1'b0;
      if (start) begin
        active     <= 1'b1;
        phase      <= 1'b0;
        cnt        <= '0;
        cur        <= head;
        sh         <= head.data;
        frame_open <= 1'b1;
        if (!frame_open) hold_l <= hold_frame;
        prev_mode  <= head.mode;
        mode_err   <= conflict;
      end else if (rise) begin
        phase <= 1'b1;
        rsh   <= shift_in(rsh, lane_in, cur.mode);
      end else if (fall) begin
        phase <= 1'b0;
        if (byte_done) begin
          active <= 1'b0;
          if (releasing) frame_open <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          sh  <= shift_out(sh, cur.mode);
        end
      end
    end
  end

  assign sclk     = active && phase;
  assign fs_n     = !(frame_open && (hold_l || (active && cnt == 3'd0)));
  assign lane_oe  = drive ? lane_mask(cur.mode) : 4'h0;
  assign lane_out = drive ? (out_bits(sh, cur.mode) & lane_mask(cur.mode)) : 4'h0;
  assign busy     = frame_open || active;

  // R2: lanes hold still while the serial clock is high
  a_r2_lanes_still_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(lane_out));
  // R4: frame select is released only with the serial clock low
  a_r4_release_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_n) |-> !sclk);
  // R8: busy covers every cycle with frame select low
  a_r8_busy_covers_fs: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_n |-> busy);
  // R7: the error is a single-cycle pulse
  a_r7_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> !mode_err);
  // R6: a captured byte is pushed on the falling edge after the last rise
  a_r6_push_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> sclk);
endmodule

// File: rtl/mls_master.sv
module mls_master
  import mls_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold_frame,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_eom,
  input  logic [1:0] tx_mode,
  input  logic       tx_rx,
  output logic       tx_full,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  output logic       sclk,
  output logic       fs_n,
  output logic [3:0] lane_out,
  output logic [3:0] lane_oe,
  input  logic [3:0] lane_in,
  output logic       busy,
  output logic       mode_err
);
  entry_t               wr_entry;
  logic [ENTRY_W-1:0]   tx_head_bits;
  logic                 tx_empty, tx_pop, rx_push;
  logic [7:0]           rx_byte;
  logic                 rx_full;

  assign wr_entry = '{data: tx_data, eom: tx_eom, rx_dir: tx_rx, mode: lane_mode_e'(tx_mode)};

  mls_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) tx_q (
    .clk(clk), .rst_n(rst_n),
    .wr(tx_wr), .din(wr_entry), .full(tx_full),
    .rd(tx_pop), .dout(tx_head_bits), .empty(tx_empty)
  );

  mls_engine eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_frame(hold_frame),
    .head(entry_t'(tx_head_bits)), .head_valid(!tx_empty), .pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .sclk(sclk), .fs_n(fs_n), .lane_out(lane_out), .lane_oe(lane_oe),
    .lane_in(lane_in), .busy(busy), .mode_err(mode_err)
  );

  mls_fifo #(.W(8), .DEPTH(RX_DEPTH)) rx_q (
    .clk(clk), .rst_n(rst_n),
    .wr(rx_push), .din(rx_byte), .full(rx_full),
    .rd(rx_rd), .dout(rx_data), .empty(rx_empty)
  );
endmodule

// File: tb/mls_master_tb_top.sv
`timescale 1ns/1ps
module mls_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       hold_frame = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_eom = 1'b0;
  logic [1:0] tx_mode = '0;
  logic       tx_rx = 1'b0;
  logic       tx_full;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_empty;
  logic       sclk, fs_n, busy, mode_err;
  logic [3:0] lane_out, lane_oe;
  logic [3:0] lane_in = '0;

  int checks = 0, errors = 0;
  int div = 1;
  int cyc = 0;

  logic [1:0] exp_mode [64];
  logic [7:0] exp_pat  [64];
  logic [7:0] obs      [64];
  logic [3:0] oe_seen  [64];
  int         fs_low   [64];
  int         gap      [64];
  int nb = 0, wr_idx = 0, fs_falls = 0, err_pulses = 0, r2_viol = 0;

  always #4 clk = ~clk;

  mls_master dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_frame(hold_frame),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_eom(tx_eom), .tx_mode(tx_mode), .tx_rx(tx_rx),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
    .sclk(sclk), .fs_n(fs_n), .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in),
    .busy(busy), .mode_err(mode_err)
  );

  function automatic int kof(logic [1:0] m);
    return (m == 2'b10) ? 4 : (m == 2'b01) ? 2 : 1;
  endfunction

  function automatic logic [3:0] chunk(logic [7:0] pat, int r, int k);
    logic [7:0] s;
    s = pat << (k * r);
    if (k == 4) return s[7:4];
    if (k == 2) return {2'b00, s[7:6]};
    return {2'b00, s[7], 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tick generator
  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 0);
      tc = (tc + 1 >= div) ? 0 : tc + 1;
    end
  end

  // lane monitor and slave model
  initial begin
    logic ps, pf;
    logic [3:0] po;
    logic [7:0] acc;
    int rises, t0, k;
    ps = 0; pf = 1; po = 0; acc = 0; rises = 0; t0 = 0;
    for (int i = 0; i < 64; i++) begin
      exp_mode[i] = 0; exp_pat[i] = 0; obs[i] = 0; oe_seen[i] = 0; fs_low[i] = 0; gap[i] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        k = kof(exp_mode[nb]);
        if (sclk && !ps) begin
          if (rises == 0) t0 = cyc;
          if (rises == 1) gap[nb] = cyc - t0;
          acc = (acc << k) | {4'b0, lane_out};
          oe_seen[nb] = oe_seen[nb] | lane_oe;
          if (!fs_n) fs_low[nb]++;
          rises++;
          if (rises == 8 / k) begin
            obs[nb] = acc; acc = 0; rises = 0; nb++;
          end
        end
        if (sclk && ps && lane_out != po) r2_viol++;
        if (!fs_n && pf) fs_falls++;
        if (mode_err) err_pulses++;
        if (!sclk) lane_in = chunk(exp_pat[nb], rises, kof(exp_mode[nb]));
      end
      ps = sclk; pf = fs_n; po = lane_out;
    end
  end

  task automatic push(input logic [7:0] d, input bit eom, input logic [1:0] m,
                      input bit dir, input logic [7:0] pat);
    exp_mode[wr_idx] = m;
    exp_pat[wr_idx]  = pat;
    wr_idx++;
    @(negedge clk);
    tx_wr = 1; tx_data = d; tx_eom = eom; tx_mode = m; tx_rx = dir;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (nb == wr_idx && !busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(output int n, output logic [7:0] first);
    n = 0; first = 0;
    while (!rx_empty && n < 16) begin
      if (n == 0) first = rx_data;
      rx_rd = 1; @(negedge clk); rx_rd = 0;
      n++;
    end
  endtask

  task automatic t_reset();
    chk(fs_n == 1, "R9 fs_n", fs_n, 1);
    chk(sclk == 0, "R9 sclk", sclk, 0);
    chk(lane_oe == 0, "R9 lane_oe", lane_oe, 0);
    chk(busy == 0 && mode_err == 0, "R9 busy/err", {busy, mode_err}, 0);
    chk(rx_empty == 1, "R9 rx_empty", rx_empty, 1);
  endtask

  task automatic t_single();
    int b, f0, n; logic [7:0] v;
    hold_frame = 0; b = wr_idx; f0 = fs_falls;
    push(8'h96, 1, 2'b00, 0, 8'h3C);
    wait_done();
    chk(obs[b] == 8'h96, "R1 single byte", obs[b], 8'h96);
    chk(oe_seen[b] == 4'h1, "R6 single drives lane0", oe_seen[b], 1);
    chk(fs_low[b] == 1, "R3 fs one clock", fs_low[b], 1);
    chk(gap[b] == 2, "R2 period fast", gap[b], 2);
    chk(fs_falls - f0 == 1, "R3 one fall", fs_falls - f0, 1);
    drain(n, v);
    chk(n == 1 && v == 8'h3C, "R6 single capture", v, 8'h3C);
  endtask

  task automatic t_multi_tx();
    int b, f0, n; logic [7:0] v;
    hold_frame = 0; b = wr_idx; f0 = fs_falls;
    push(8'hA7, 0, 2'b10, 0, 8'h00);
    push(8'h5B, 0, 2'b01, 0, 8'h00);
    wait_done();
    chk(obs[b] == 8'hA7, "R1 quad byte", obs[b], 8'hA7);
    chk(obs[b+1] == 8'h5B, "R1 dual byte", obs[b+1], 8'h5B);
    chk(oe_seen[b] == 4'hF && oe_seen[b+1] == 4'h3, "R1 lane enables",
        {oe_seen[b], oe_seen[b+1]}, 8'hF3);
    chk(fs_falls - f0 == 2 && fs_low[b] == 1 && fs_low[b+1] == 1, "R3 per byte frames",
        fs_falls - f0, 2);
    drain(n, v);
    chk(n == 0, "R6 tx-only pushes nothing", n, 0);
  endtask

  task automatic t_held();
    int b, f0, e0, n; logic [7:0] v;
    hold_frame = 1; b = wr_idx; f0 = fs_falls; e0 = err_pulses;
    // back-to-back writes: second write meets first pop
    exp_mode[wr_idx] = 2'b00; exp_pat[wr_idx] = 8'h00; wr_idx++;
    exp_mode[wr_idx] = 2'b01; exp_pat[wr_idx] = 8'h00; wr_idx++;
    exp_mode[wr_idx] = 2'b00; exp_pat[wr_idx] = 8'h00; wr_idx++;
    @(negedge clk);
    tx_wr = 1; tx_data = 8'h11; tx_eom = 0; tx_mode = 2'b00; tx_rx = 0;
    @(negedge clk);
    tx_data = 8'h22; tx_mode = 2'b01;
    @(negedge clk);
    tx_data = 8'h33; tx_mode = 2'b00; tx_eom = 1;
    @(negedge clk);
    tx_wr = 0; tx_eom = 0;
    hold_frame = 0; // latched at frame start, change must not matter
    wait_done();
    chk(obs[b] == 8'h11 && obs[b+1] == 8'h22 && obs[b+2] == 8'h33, "R4 held order",
        obs[b+1], 8'h22);
    chk(fs_falls - f0 == 1, "R4 single fall", fs_falls - f0, 1);
    chk(fs_low[b] == 8 && fs_low[b+1] == 4 && fs_low[b+2] == 8, "R4 fs held low",
        fs_low[b+1], 4);
    chk(fs_n == 1 && busy == 0, "R8 released after eom", {fs_n, busy}, 2'b10);
    chk(err_pulses == e0, "R7 single switches no error", err_pulses - e0, 0);
    drain(n, v);
    chk(n == 2, "R6 held single captures", n, 2);
  endtask

  task automatic t_gap();
    int b, f0;
    hold_frame = 1; b = wr_idx; f0 = fs_falls;
    push(8'h44, 0, 2'b10, 0, 8'h00);
    for (int i = 0; i < 200 && nb != wr_idx; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(sclk == 0 && fs_n == 0, "R5 stalled with fs low", {sclk, fs_n}, 0);
    chk(busy == 1, "R8 busy in gap", busy, 1);
    push(8'h55, 1, 2'b10, 0, 8'h00);
    wait_done();
    chk(obs[b] == 8'h44 && obs[b+1] == 8'h55, "R5 resumes", obs[b+1], 8'h55);
    chk(fs_falls - f0 == 1 && fs_n == 1, "R4 one fall over gap", fs_falls - f0, 1);
  endtask

  task automatic t_err();
    int b, e0;
    hold_frame = 1; b = wr_idx; e0 = err_pulses;
    push(8'h66, 0, 2'b01, 0, 8'h00);
    push(8'h77, 1, 2'b10, 0, 8'h00);
    wait_done();
    chk(err_pulses - e0 == 1, "R7 dual to quad flagged", err_pulses - e0, 1);
    chk(obs[b+1] == 8'h77 && oe_seen[b+1] == 4'hF, "R7 byte still quad", obs[b+1], 8'h77);
  endtask

  task automatic t_rx();
    int b, n; logic [7:0] v;
    hold_frame = 0; b = wr_idx;
    push(8'hFF, 0, 2'b10, 1, 8'hC3);
    wait_done();
    chk(oe_seen[b] == 4'h0, "R6 quad rx releases lanes", oe_seen[b], 0);
    drain(n, v);
    chk(n == 1 && v == 8'hC3, "R6 quad capture", v, 8'hC3);
    b = wr_idx;
    push(8'hFF, 0, 2'b01, 1, 8'h5A);
    wait_done();
    drain(n, v);
    chk(n == 1 && v == 8'h5A && oe_seen[b] == 0, "R6 dual capture", v, 8'h5A);
  endtask

  task automatic t_slow();
    int b;
    hold_frame = 0; div = 3; b = wr_idx;
    push(8'hE1, 1, 2'b11, 0, 8'h00);
    wait_done();
    chk(obs[b] == 8'hE1 && oe_seen[b] == 4'h1, "R1 mode 11 as single", obs[b], 8'hE1);
    chk(gap[b] == 6, "R2 period two ticks", gap[b], 6);
    chk(r2_viol == 0, "R2 lanes stable while high", r2_viol, 0);
    div = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single();
    t_multi_tx();
    t_held();
    t_gap();
    t_err();
    t_rx();
    t_slow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule